// File: doc/BRIEF.md
# Phase-Aligned Three-Bank Clock Divider

This block sits after a high-rate synthesizer clock and produces three banks of derived clocks, A, B and C. Each bank divides the input by one of four fixed ratios (16, 20, 25 or 100), picked by a two-bit code. Every bank's rising edges line up with the others at a common alignment point. That point recurs every 400 input cycles, which is the least common multiple of the ratio set. New divide codes are taken up only at that point, so the banks never drift apart in phase.

Bank A has five outputs. Each of them has an enable that drives an output-enable flag, which stands in for a high-impedance driver. The two highest A outputs, all four B outputs and all four C outputs each carry a phase-inversion bit, so that pairs of single-ended outputs can be run as complements. A separate reference pre-divider counts strobes from the reference path and divides them by 1, 2, 4 or 8. The control bytes come from an external register file.

Top module: `bank_clk_div`

## Requirements
- R1: Each bank's two-bit code sets its output period in input cycles: 00 gives 16, 01 gives 20, 10 gives 25 and 11 gives 100.
- R2: Each output stays high for the first ceil(N/2) input cycles of its period: 8 for a ratio of 16, 10 for 20, 13 for 25 and 50 for 100.
- R3: Non-inverted outputs of all three banks rise in the same cycle once every 400 input cycles. With the A, B and C ratios set to 16, 20 and 25, there are no other cycles in which all three rise together.
- R4: A change of `div_ctrl` takes effect only at the next alignment point. Alignment points fall every 400 cycles, counted from the release of reset. Until then, the previous ratios continue unchanged.
- R5: While reset is held, every `qa`, `qa_oe`, `qb`, `qc` and `ref_pulse` bit is 0. From the release of reset until the first alignment point, the block uses these codes regardless of `div_ctrl`: A = 01 (÷20), B = 11 (÷100), C = 10 (÷25), pre-divider = 11 (÷8).
- R6: `inv_ctrl` bit positions are: [0] A3, [1] A4, [5:2] B0..B3, [9:6] C0..C3. A bit of 1 makes that output the complement of a non-inverted output of the same bank. A bit of 0 leaves it in phase with the other outputs.
- R7: Clearing `a_en[i]` lets any high phase already under way on `qa[i]` run its full length. `qa_oe[i]` falls one cycle after `qa[i]` has gone low. A disabled output stays low. Setting `a_en[i]` again raises `qa_oe[i]` on the next cycle, and the output resumes with full-length high phases.
- R8: `ref_pulse` is a one-cycle strobe, issued once for every N `ref_tick` strobes, one cycle after the Nth tick. Pre-divider code 00 gives N = 1, 01 gives 2, 10 gives 4 and 11 gives 8.
- R9: `div_ctrl` fields are: [1:0] bank A code, [3:2] bank B code, [5:4] bank C code, [7:6] pre-divider code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | High-rate clock from the synthesizer core |
| rst_n | input | 1 | Active-low synchronous reset |
| div_ctrl | input | 8 | Divide codes for the pre-divider and banks A, B and C |
| inv_ctrl | input | 10 | Per-output phase inversion bits |
| a_en | input | 5 | Per-output enables for bank A |
| ref_tick | input | 1 | One strobe per reference cycle |
| qa | output | 5 | Bank A clock outputs |
| qa_oe | output | 5 | Bank A output-enable flags |
| qb | output | 4 | Bank B clock outputs |
| qc | output | 4 | Bank C clock outputs |
| ref_pulse | output | 1 | Divided reference strobe |

## Verification
Each bank output is registered once after its counter, so an edge reaches the pins one cycle after the counter wraps. The bench therefore measures periods and high times as run lengths at falling-edge samples, and never assumes an absolute phase. Divide codes take effect at the posedge that ends each 400-cycle frame. The bench counts cycles from reset release and starts every ratio measurement ten cycles into a frame, finishing it before the next frame begins. A pre-divider strobe is due one cycle after its tick and is sampled at the very next falling edge. The enable handshake is checked edge by edge: the output falls first, and the enable flag drops one cycle later.

// File: rtl/bcd_pkg.sv
`timescale 1ns/1ps
package bcd_pkg;
    typedef logic [1:0] code_t;

    localparam int unsigned CNT_W     = 7;
    localparam int unsigned ALIGN_LEN = 400;
    localparam int unsigned HYP_W     = $clog2(ALIGN_LEN);
    localparam int unsigned PRE_W     = 3;

    localparam code_t RST_A = 2'b01;
    localparam code_t RST_B = 2'b11;
    localparam code_t RST_C = 2'b10;
    localparam code_t RST_P = 2'b11;

    function automatic int unsigned ratio_of(code_t c);
        case (c)
            2'b00:   return 16;
            2'b01:   return 20;
            2'b10:   return 25;
            default: return 100;
        endcase
    endfunction

    function automatic int unsigned high_of(code_t c);
        return (ratio_of(c) + 1) / 2;
    endfunction

    function automatic int unsigned prediv_of(code_t c);
        return 1 << c;
    endfunction
endpackage

// File: rtl/bank_divider.sv
`timescale 1ns/1ps
module bank_divider
    import bcd_pkg::*;
#(
    parameter int unsigned W = CNT_W
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  restart,
    input  code_t code,
    output logic  base
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } div_st_t;

    div_st_t s_d, s_q;
    logic    at_end;

    always_comb begin
        s_d    = s_q;
        at_end = (s_q.cnt == W'(ratio_of(code) - 1));
        if (restart || at_end) s_d.cnt = '0;
        else                   s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // high for the first ceil(N/2) counts; odd ratio keeps the extra count high
    assign base = (s_q.cnt < W'(high_of(code)));
endmodule

// File: rtl/ref_prediv.sv
`timescale 1ns/1ps
module ref_prediv
    import bcd_pkg::*;
#(
    parameter int unsigned W = PRE_W
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick,
    input  code_t code,
    output logic  pulse
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         pulse;
    } pre_st_t;

    pre_st_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.pulse = 1'b0;
        if (tick) begin
            // >= so a shrinking ratio wraps at once instead of overrunning
            if (s_q.cnt >= W'(prediv_of(code) - 1)) begin
                s_d.cnt   = '0;
                s_d.pulse = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pulse = s_q.pulse;
endmodule

// File: rtl/a_lane_gate.sv
`timescale 1ns/1ps
module a_lane_gate #(
    parameter int unsigned WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base,
    input  logic [WIDTH-1:0] inv,
    input  logic [WIDTH-1:0] en,
    output logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] oe
);
    typedef struct packed {
        logic [WIDTH-1:0] q;
        logic [WIDTH-1:0] gate;
        logic [WIDTH-1:0] oe;
    } lane_st_t;

    lane_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < WIDTH; i++) begin
            logic raw;
            raw = base ^ inv[i];
            // the gate moves only while the lane would be low: no partial pulses
            if (!raw) s_d.gate[i] = en[i];
            s_d.q[i]  = raw & s_q.gate[i];
            // the flag follows the gate one cycle late when disabling
            s_d.oe[i] = en[i] | s_q.gate[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q  = s_q.q;
    assign oe = s_q.oe;
endmodule

// File: rtl/bank_clk_div.sv
`timescale 1ns/1ps
module bank_clk_div
    import bcd_pkg::*;
#(
    parameter int unsigned A_OUTS      = 5,
    parameter int unsigned B_OUTS      = 4,
    parameter int unsigned C_OUTS      = 4,
    parameter int unsigned A_INV_FIRST = 3,
    parameter int unsigned INV_W       = (A_OUTS - A_INV_FIRST) + B_OUTS + C_OUTS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        div_ctrl,
    input  logic [INV_W-1:0]  inv_ctrl,
    input  logic [A_OUTS-1:0] a_en,
    input  logic              ref_tick,
    output logic [A_OUTS-1:0] qa,
    output logic [A_OUTS-1:0] qa_oe,
    output logic [B_OUTS-1:0] qb,
    output logic [C_OUTS-1:0] qc,
    output logic              ref_pulse
);
    localparam int unsigned INV_A_N = A_OUTS - A_INV_FIRST;
    localparam int unsigned A_LSB   = 0;
    localparam int unsigned B_LSB   = 2;
    localparam int unsigned C_LSB   = 4;
    localparam int unsigned P_LSB   = 6;

    typedef struct packed {
        logic [HYP_W-1:0]  hyper;
        code_t             a_code;
        code_t             b_code;
        code_t             c_code;
        code_t             p_code;
        logic [B_OUTS-1:0] qb;
        logic [C_OUTS-1:0] qc;
    } top_st_t;

    top_st_t s_d, s_q;

    logic              wrap;
    logic              base_a, base_b, base_c;
    logic [A_OUTS-1:0] inv_a;
    logic [B_OUTS-1:0] inv_b;
    logic [C_OUTS-1:0] inv_c;

    for (genvar gi = 0; gi < A_OUTS; gi++) begin : g_inv_a
        if (gi >= A_INV_FIRST) begin : g_inv
            assign inv_a[gi] = inv_ctrl[gi - A_INV_FIRST];
        end else begin : g_fixed
            assign inv_a[gi] = 1'b0;
        end
    end
    assign inv_b = inv_ctrl[INV_A_N +: B_OUTS];
    assign inv_c = inv_ctrl[INV_A_N + B_OUTS +: C_OUTS];

    assign wrap = (s_q.hyper == HYP_W'(ALIGN_LEN - 1));

    always_comb begin
        s_d = s_q;
        if (wrap) begin
            s_d.hyper  = '0;
            s_d.a_code = div_ctrl[A_LSB +: 2];
            s_d.b_code = div_ctrl[B_LSB +: 2];
            s_d.c_code = div_ctrl[C_LSB +: 2];
            s_d.p_code = div_ctrl[P_LSB +: 2];
        end else begin
            s_d.hyper = s_q.hyper + 1'b1;
        end
        s_d.qb = {B_OUTS{base_b}} ^ inv_b;
        s_d.qc = {C_OUTS{base_c}} ^ inv_c;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{hyper: '0, a_code: RST_A, b_code: RST_B, c_code: RST_C,
                     p_code: RST_P, qb: '0, qc: '0};
        end else begin
            s_q <= s_d;
        end
    end

    bank_divider u_div_a (.clk(clk), .rst_n(rst_n), .restart(wrap), .code(s_q.a_code), .base(base_a));
    bank_divider u_div_b (.clk(clk), .rst_n(rst_n), .restart(wrap), .code(s_q.b_code), .base(base_b));
    bank_divider u_div_c (.clk(clk), .rst_n(rst_n), .restart(wrap), .code(s_q.c_code), .base(base_c));

    a_lane_gate #(.WIDTH(A_OUTS)) u_lanes_a (
        .clk(clk), .rst_n(rst_n), .base(base_a), .inv(inv_a), .en(a_en),
        .q(qa), .oe(qa_oe)
    );

    ref_prediv u_pre (
        .clk(clk), .rst_n(rst_n), .tick(ref_tick), .code(s_q.p_code), .pulse(ref_pulse)
    );

    assign qb = s_q.qb;
    assign qc = s_q.qc;
endmodule

// File: rtl/bank_clk_div_chk.sv
`timescale 1ns/1ps
module bank_clk_div_chk
    import bcd_pkg::*;
#(
    parameter int unsigned A_OUTS = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [HYP_W-1:0]  hyper_q,
    input logic              base_a,
    input logic              base_b,
    input logic              base_c,
    input logic [7:0]        codes_q,
    input logic [7:0]        div_ctrl,
    input logic [A_OUTS-1:0] qa,
    input logic [A_OUTS-1:0] qa_oe,
    input logic              ref_tick,
    input logic              ref_pulse
);
    p_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hyper_q == '0) |-> (base_a && base_b && base_c));

    p_load_only_at_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(codes_q) |-> ($past(hyper_q) == HYP_W'(ALIGN_LEN - 1)));

    p_load_fields_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((hyper_q == '0) && ($past(hyper_q) == HYP_W'(ALIGN_LEN - 1)))
        |-> (codes_q == $past(div_ctrl)));

    p_pulse_follows_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse |-> $past(ref_tick));

    for (genvar gi = 0; gi < A_OUTS; gi++) begin : g_lane
        p_oe_after_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(qa_oe[gi]) |-> !$past(qa[gi]));

        p_low_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !qa_oe[gi] |-> !qa[gi]);
    end
endmodule

bind bank_clk_div bank_clk_div_chk #(.A_OUTS(A_OUTS)) u_chk (
    .clk(clk), .rst_n(rst_n), .hyper_q(s_q.hyper),
    .base_a(base_a), .base_b(base_b), .base_c(base_c),
    .codes_q({s_q.p_code, s_q.c_code, s_q.b_code, s_q.a_code}),
    .div_ctrl(div_ctrl), .qa(qa), .qa_oe(qa_oe),
    .ref_tick(ref_tick), .ref_pulse(ref_pulse)
);

// File: tb/bank_clk_div_test.sv
`timescale 1ns/1ps
module bank_clk_div_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div_ctrl = 8'h00;
    logic [9:0] inv_ctrl = 10'h000;
    logic [4:0] a_en = 5'h1f;
    logic       ref_tick = 1'b0;
    logic [4:0] qa, qa_oe;
    logic [3:0] qb, qc;
    logic       ref_pulse;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int sel = 0;
    logic probe;
    bit finished = 0;

    always #2 clk = ~clk;

    bank_clk_div uut (
        .clk(clk), .rst_n(rst_n), .div_ctrl(div_ctrl), .inv_ctrl(inv_ctrl),
        .a_en(a_en), .ref_tick(ref_tick), .qa(qa), .qa_oe(qa_oe),
        .qb(qb), .qc(qc), .ref_pulse(ref_pulse)
    );

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    always_comb begin
        if (sel < 10)      probe = qa[sel];
        else if (sel < 20) probe = qb[sel - 10];
        else               probe = qc[sel - 20];
    end

    function automatic int exp_per(input logic [1:0] c);
        case (c)
            2'b00:   return 16;
            2'b01:   return 20;
            2'b10:   return 25;
            default: return 100;
        endcase
    endfunction

    function automatic int exp_hi(input logic [1:0] c);
        case (c)
            2'b00:   return 8;
            2'b01:   return 10;
            2'b10:   return 13;
            default: return 50;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [7:0] dc);
        rst_n    = 1'b0;
        div_ctrl = dc;
        inv_ctrl = '0;
        a_en     = 5'h1f;
        ref_tick = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_align();
        do @(negedge clk); while ((cyc % 400) != 10);
    endtask

    task automatic measure(input int s, output int per, output int hi);
        int   guard;
        logic last;
        sel   = s;
        guard = 0;
        @(negedge clk);
        while (probe !== 1'b0 && guard < 1000) begin @(negedge clk); guard++; end
        while (probe !== 1'b1 && guard < 1000) begin @(negedge clk); guard++; end
        per  = 0;
        hi   = 0;
        last = 1'b1;
        while (guard < 2000) begin
            if (per > 0 && probe === 1'b1 && last === 1'b0) break;
            if (probe === 1'b1) hi++;
            per++;
            last = probe;
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic check_ratio(input int s, input logic [1:0] code, input string tag);
        int per, hi;
        measure(s, per, hi);
        check(per == exp_per(code), {tag, " R1 period"}, per, exp_per(code));
        check(hi == exp_hi(code), {tag, " R2 high time"}, hi, exp_hi(code));
    endtask

    task automatic run_ticks(input int n_exp, input string tag);
        int idx[3];
        int np;
        np = 0;
        for (int t = 0; t < 60 && np < 3; t++) begin
            @(negedge clk) ref_tick = 1'b1;
            @(negedge clk) ref_tick = 1'b0;
            if (ref_pulse === 1'b1) begin
                idx[np] = t;
                np++;
            end
            @(negedge clk);
        end
        check(np == 3 && (idx[2] - idx[1]) == n_exp, tag,
              (np == 3) ? idx[2] - idx[1] : -1, n_exp);
    endtask

    // R5: reset state
    task automatic t_reset_state();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check({qa, qa_oe, qb, qc, ref_pulse} == '0, "R5 outputs in reset",
              int'({qa, qa_oe, qb, qc, ref_pulse}), 0);
    endtask

    // R5: default codes before the first alignment point
    task automatic t_defaults();
        do_reset(8'h00);
        run_ticks(8, "R5 default pre-divider");
        do_reset(8'h00);
        check_ratio(10, 2'b11, "R5 default bank B");
        check_ratio(0, 2'b01, "R5 default bank A");
        check_ratio(20, 2'b10, "R5 default bank C");
    endtask

    // R1 R2 R9: every code on every bank, different codes per bank
    task automatic t_ratios();
        for (int k = 0; k < 4; k++) begin
            logic [1:0] ca, cb, cc;
            ca = 2'(k);
            cb = 2'(k + 1);
            cc = 2'(k + 2);
            div_ctrl = {2'b00, cc, cb, ca};
            wait_align();
            check_ratio(0, ca, "R9 bank A field");
            wait_align();
            check_ratio(13, cb, "R9 bank B field");
            wait_align();
            check_ratio(22, cc, "R9 bank C field");
        end
    endtask

    // R3: common rising edges
    task automatic t_align();
        int all3, ab;
        logic pa, pb, pc;
        div_ctrl = 8'b00_10_01_00;
        inv_ctrl = '0;
        wait_align();
        wait_align();
        all3 = 0;
        ab   = 0;
        pa = qa[0]; pb = qb[0]; pc = qc[0];
        for (int i = 0; i < 800; i++) begin
            @(negedge clk);
            if (qa[0] && !pa && qb[0] && !pb && qc[0] && !pc) all3++;
            if (qa[0] && !pa && qb[0] && !pb) ab++;
            pa = qa[0]; pb = qb[0]; pc = qc[0];
        end
        check(all3 == 2, "R3 three-bank common rises in 800 cycles", all3, 2);
        check(ab == 10, "R3 A/B common rises in 800 cycles", ab, 10);
    endtask

    // R4: codes held until the alignment point
    task automatic t_hold();
        div_ctrl = 8'h00;
        wait_align();
        wait_align();
        div_ctrl = 8'b00_00_00_11;
        check_ratio(0, 2'b00, "R4 old ratio kept");
        wait_align();
        check_ratio(0, 2'b11, "R4 new ratio after alignment");
    endtask

    // R6: inversion
    task automatic t_invert();
        int bad_a4, bad_a3, bad_b1, bad_c0;
        div_ctrl = 8'b00_10_01_00;
        inv_ctrl = 10'b00_0100_1010;   // A4, B1, C0
        wait_align();
        bad_a4 = 0; bad_a3 = 0; bad_b1 = 0; bad_c0 = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (qa[4] !== ~qa[0]) bad_a4++;
            if (qa[3] !== qa[0])  bad_a3++;
            if (qb[1] !== ~qb[0]) bad_b1++;
            if (qc[0] !== ~qc[1]) bad_c0++;
        end
        check(bad_a4 == 0, "R6 A4 complement of A0", bad_a4, 0);
        check(bad_a3 == 0, "R6 A3 in phase with A0", bad_a3, 0);
        check(bad_b1 == 0, "R6 B1 complement of B0", bad_b1, 0);
        check(bad_c0 == 0, "R6 C0 complement of C1", bad_c0, 0);
        inv_ctrl = '0;
    endtask

    // R7: enable handshake
    task automatic t_enable();
        int hi, stray, per;
        div_ctrl = 8'b00_00_00_01;
        a_en = 5'h1f;
        wait_align();
        while (qa[2] !== 1'b0) @(negedge clk);
        while (qa[2] !== 1'b1) @(negedge clk);
        hi = 0;
        repeat (3) begin hi++; @(negedge clk); end
        a_en[2] = 1'b0;
        while (qa[2] === 1'b1) begin hi++; @(negedge clk); end
        check(hi == 10, "R7 high phase not cut by disable", hi, 10);
        check(qa_oe[2] === 1'b1, "R7 enable flag held while output falls", int'(qa_oe[2]), 1);
        @(negedge clk);
        check(qa_oe[2] === 1'b0, "R7 enable flag drops one cycle later", int'(qa_oe[2]), 0);
        stray = 0;
        repeat (60) begin
            @(negedge clk);
            if (qa[2] !== 1'b0 || qa_oe[2] !== 1'b0) stray++;
        end
        check(stray == 0, "R7 disabled output stays low", stray, 0);
        a_en[2] = 1'b1;
        @(negedge clk);
        check(qa_oe[2] === 1'b1, "R7 enable flag rises next cycle", int'(qa_oe[2]), 1);
        measure(2, per, hi);
        check(hi == 10 && per == 20, "R7 re-enabled output full pulses", hi, 10);
    endtask

    // R8: pre-divider ratios
    task automatic t_prediv();
        for (int k = 0; k < 4; k++) begin
            div_ctrl = {2'(k), 6'b00_00_00};
            wait_align();
            run_ticks(1 << k, "R8 pre-divider tick count");
        end
    endtask

    initial begin
        t_reset_state();
        t_defaults();
        t_ratios();
        t_align();
        t_hold();
        t_invert();
        t_enable();
        t_prediv();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule